// File: doc/BRIEF.md
# DMA Channel Result and Interrupt Register Bank

This block is the software-facing register bank for a set of DMA channel engines as seen from a single execution domain. Software writes a command-list pointer into a channel's command register. The bank passes that pointer to the channel engine with a one-cycle start pulse. A channel that is already running can hold one more pointer, which it launches as soon as the engine reports completion.

When an engine finishes, whether normally, with an error, or because software flushed it, the bank builds a result word and places it in a small per-channel queue. Software reads the result register to take the oldest result from the queue. A per-channel status register shows whether the channel is busy, whether a result is waiting, whether a command is queued, and whether a result was ever dropped.

A summary register holds one bit per channel that has a reportable result. The single interrupt output combines the summary bits of the channels whose interrupt is enabled. Software can abort a running transfer by writing any value to that channel's flush register.

Top module: `dma_result_bank`

## Requirements
- R1: A word-aligned write to the command register of channel n (byte offset 0x000 + 4n) while the channel is idle drives `eng_start[n]` high for exactly the next cycle. In that cycle `eng_ptr[32n +: 32]` equals the written value, and status bit 0 (busy) reads 1.
- R2: A command write to a busy channel with no queued command is held as the queued command, shown by status bit 5. When the engine then reports done, the queued pointer is started in the following cycle. A command write while a command is already queued is ignored.
- R3: An `eng_done[n]` pulse while channel n is busy appends a result word: bit 31 = 1, bit 3 = `eng_err[n]`, bit 2 = `eng_flushed[n]`, bit 1 = 1 only when neither error nor flushed is set, and all other bits 0. The pulse also clears busy when no command is queued. Status bit 1 reads 1 while any result is held.
- R4: A read of the result register (0x040 + 4n) returns the oldest held result and removes it. The next held result is returned by the next read. A read with nothing held returns 0.
- R5: Each channel holds at most 2 results. A result that arrives while both entries are full is dropped, and status bit 4 is set and stays set until reset.
- R6: Bit n of the summary register (0x380) is 1 when channel n holds a result. If that oldest result has its flushed bit set, the summary bit is 1 only while config bit 1 of that channel is 1.
- R7: `irq` is high exactly when some channel has its summary bit set and its config bit 0 (interrupt enable) set.
- R8: Any write to the flush register (0x080 + 4n) while channel n is busy drives `eng_flush[n]` high for exactly the next cycle. Such a write to an idle channel produces no pulse.
- R9: The config register (0x300 + 4n) stores bits [1:0] of the written data and reads them back, with all other bits 0. After reset every status, config, summary, start, flush and irq output is 0.
- R10: A read returns its data on `bus_rdata` in the cycle after `bus_rd`, and the value holds until the next read. Command and flush registers read as 0.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| eng_done | input | NCH | Per-channel completion pulse from the engines |
| eng_err | input | NCH | Error flag qualifying the completion pulse |
| eng_flushed | input | NCH | Flushed flag qualifying the completion pulse |
| eng_start | output | NCH | Per-channel start pulse |
| eng_ptr | output | 32*NCH | Per-channel command-list pointer, valid with start |
| eng_flush | output | NCH | Per-channel abort pulse |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted busy or queued-command flag becomes visible at the engine ports within one cycle. It shows up as a missing, extra or wrongly-addressed start pulse after a command write or a completion. A damaged result queue shows at the result register on the next read, as a wrong order, a lost second entry, or a non-zero read from an empty queue. A drop that should have happened shows in the sticky overflow bit. Errors in the summary or flush-report gating reach `irq` in the same cycle as the config change or result arrival that exposes them, so the bench samples `irq` right after each such event.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    // Register regions, selected by address bits [11:6]
    localparam logic [5:0] RG_CMD   = 6'h00;
    localparam logic [5:0] RG_RSLT  = 6'h01;
    localparam logic [5:0] RG_FLUSH = 6'h02;
    localparam logic [5:0] RG_STAT  = 6'h08;
    localparam logic [5:0] RG_CFG   = 6'h0C;
    localparam logic [5:0] RG_SUMM  = 6'h0E;

    localparam int MAX_CH = 16;

    // Status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_AVAIL = 1;
    localparam int ST_OVF   = 4;
    localparam int ST_QUEUE = 5;

    // Result word bit positions
    localparam int RS_VALID = 31;
    localparam int RS_ERR   = 3;
    localparam int RS_FLUSH = 2;
    localparam int RS_DONE  = 1;

    // Compact stored form of a result
    typedef struct packed {
        logic err;
        logic fl;
    } rslt_t;

    // Per-channel access strobes decoded from the bus
    typedef struct packed {
        logic cmd_wr;
        logic flush_wr;
        logic cfg_wr;
        logic rslt_rd;
    } ch_acc_t;

    function automatic logic [31:0] pack_result(rslt_t r);
        logic [31:0] w;
        w           = '0;
        w[RS_VALID] = 1'b1;
        w[RS_ERR]   = r.err;
        w[RS_FLUSH] = r.fl;
        w[RS_DONE]  = !r.err && !r.fl;
        return w;
    endfunction

endpackage

// File: rtl/dmarb_result_fifo.sv
module dmarb_result_fifo #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R5: occupancy never exceeds the configured depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R4: popping the only entry with no push leaves the queue empty
    a_r4_pop_last: assert property (@(posedge clk) disable iff (rst)
        (pop && count == CW'(1) && !push) |=> empty);

endmodule

// File: rtl/dmarb_channel.sv
module dmarb_channel
    import dmarb_pkg::*;
#(
    parameter int RQ_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_acc_t       acc,
    input  logic [31:0]   wdata,
    input  logic          eng_done,
    input  logic          eng_err,
    input  logic          eng_flushed,
    output logic          start,
    output logic [31:0]   start_ptr,
    output logic          flush,
    output logic [31:0]   rslt_word,
    output logic [31:0]   status,
    output logic [1:0]    cfg,
    output logic          summary
);
    logic        busy, pend_v, ovf;
    logic [31:0] pend_ptr;
    logic        busy_n, pend_v_n, start_n;
    logic [31:0] pend_ptr_n, ptr_n;
    logic        push, empty, full;
    rslt_t       head, in_r;

    // Next-state: completion first, then the bus write sees the result
    always_comb begin
        busy_n     = busy;
        pend_v_n   = pend_v;
        pend_ptr_n = pend_ptr;
        start_n    = 1'b0;
        ptr_n      = start_ptr;
        if (eng_done && busy) begin
            if (pend_v) begin
                start_n  = 1'b1;
                ptr_n    = pend_ptr;
                pend_v_n = 1'b0;
            end else begin
                busy_n = 1'b0;
            end
        end
        if (acc.cmd_wr) begin
            if (!busy_n) begin
                start_n = 1'b1;
                ptr_n   = wdata;
                busy_n  = 1'b1;
            end else if (!pend_v_n) begin
                pend_v_n   = 1'b1;
                pend_ptr_n = wdata;
            end
        end
    end

    assign push       = eng_done && busy;
    assign in_r.err   = eng_err;
    assign in_r.fl    = eng_flushed;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            pend_v    <= 1'b0;
            pend_ptr  <= '0;
            start     <= 1'b0;
            start_ptr <= '0;
            flush     <= 1'b0;
            ovf       <= 1'b0;
            cfg       <= '0;
        end else begin
            busy      <= busy_n;
            pend_v    <= pend_v_n;
            pend_ptr  <= pend_ptr_n;
            start     <= start_n;
            start_ptr <= ptr_n;
            flush     <= acc.flush_wr && busy;
            if (push && full && !acc.rslt_rd) ovf <= 1'b1;
            if (acc.cfg_wr) cfg <= wdata[1:0];
        end
    end

    dmarb_result_fifo #(.DEPTH(RQ_DEPTH), .WIDTH($bits(rslt_t))) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (in_r),
        .pop       (acc.rslt_rd),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    assign rslt_word = empty ? '0 : pack_result(head);
    assign summary   = !empty && (!head.fl || cfg[1]);

    always_comb begin
        status           = '0;
        status[ST_BUSY]  = busy;
        status[ST_AVAIL] = !empty;
        status[ST_OVF]   = ovf;
        status[ST_QUEUE] = pend_v;
    end

    // R1: a command write to an idle, non-completing channel starts it
    a_r1_idle_start: assert property (@(posedge clk) disable iff (rst)
        (acc.cmd_wr && !busy) |=> start);

    // R2: a queued command only exists while the channel runs
    a_r2_queue_needs_busy: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> busy);

    // R8: a flush pulse is only issued for a channel that was running
    a_r8_flush_busy: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(busy));

    // R5: the overflow flag never falls once set
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) |-> ovf);

endmodule

// File: rtl/dma_result_bank.sv
module dma_result_bank
    import dmarb_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int RQ_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    eng_done,
    input  logic [NCH-1:0]    eng_err,
    input  logic [NCH-1:0]    eng_flushed,
    output logic [NCH-1:0]    eng_start,
    output logic [32*NCH-1:0] eng_ptr,
    output logic [NCH-1:0]    eng_flush,
    output logic              irq
);
    logic [5:0]     region;
    logic [3:0]     chan;
    logic           aligned;
    logic [31:0]    rslt_w [NCH];
    logic [31:0]    stat_w [NCH];
    logic [1:0]     cfg_w  [NCH];
    logic [NCH-1:0] summ, ien;
    logic [31:0]    rdata_d;

    assign region  = bus_addr[11:6];
    assign chan    = bus_addr[5:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_acc_t acc;
        logic    hit;
        assign hit          = aligned && (chan == 4'(c));
        assign acc.cmd_wr   = bus_wr && hit && (region == RG_CMD);
        assign acc.flush_wr = bus_wr && hit && (region == RG_FLUSH);
        assign acc.cfg_wr   = bus_wr && hit && (region == RG_CFG);
        assign acc.rslt_rd  = bus_rd && hit && (region == RG_RSLT);

        dmarb_channel #(.RQ_DEPTH(RQ_DEPTH)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .acc         (acc),
            .wdata       (bus_wdata),
            .eng_done    (eng_done[c]),
            .eng_err     (eng_err[c]),
            .eng_flushed (eng_flushed[c]),
            .start       (eng_start[c]),
            .start_ptr   (eng_ptr[32*c +: 32]),
            .flush       (eng_flush[c]),
            .rslt_word   (rslt_w[c]),
            .status      (stat_w[c]),
            .cfg         (cfg_w[c]),
            .summary     (summ[c])
        );
        assign ien[c] = cfg_w[c][0];
    end

    assign irq = |(summ & ien);

    always_comb begin
        rdata_d = '0;
        if (aligned) begin
            if (region == RG_SUMM && chan == 4'd0) begin
                rdata_d[NCH-1:0] = summ;
            end else if (int'(chan) < NCH) begin
                case (region)
                    RG_RSLT: rdata_d = rslt_w[chan];
                    RG_STAT: rdata_d = stat_w[chan];
                    RG_CFG:  rdata_d[1:0] = cfg_w[chan];
                    default: rdata_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rdata_d;
    end

    // R7: with no reportable result anywhere the interrupt is low
    a_r7_irq_needs_summary: assert property (@(posedge clk) disable iff (rst)
        (summ == '0) |-> !irq);

    // R10: read data only changes after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R1: at most as many start pulses as there were starting events
    a_r1_single_cmd_start: assert property (@(posedge clk) disable iff (rst)
        (eng_done == '0) |=> $onehot0(eng_start));

endmodule

// File: tb/test_dma_result_bank.sv
module test_dma_result_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_wr, bus_rd;
    logic [11:0]       bus_addr;
    logic [31:0]       bus_wdata, bus_rdata;
    logic [NCH-1:0]    eng_done, eng_err, eng_flushed;
    logic [NCH-1:0]    eng_start, eng_flush;
    logic [32*NCH-1:0] eng_ptr;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_result_bank #(.NCH(NCH), .RQ_DEPTH(2)) i_dma_result_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .eng_flushed(eng_flushed),
        .eng_start(eng_start), .eng_ptr(eng_ptr), .eng_flush(eng_flush),
        .irq(irq)
    );

    function automatic logic [11:0] a_cmd(int n);   return 12'(4*n);         endfunction
    function automatic logic [11:0] a_rslt(int n);  return 12'(12'h040 + 4*n); endfunction
    function automatic logic [11:0] a_flush(int n); return 12'(12'h080 + 4*n); endfunction
    function automatic logic [11:0] a_stat(int n);  return 12'(12'h200 + 4*n); endfunction
    function automatic logic [11:0] a_cfg(int n);   return 12'(12'h300 + 4*n); endfunction
    localparam logic [11:0] A_SUMM = 12'h380;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic eng_pulse(int n, logic err, logic fl);
        @(negedge clk);
        eng_done[n] = 1'b1; eng_err[n] = err; eng_flushed[n] = fl;
        @(negedge clk);
        eng_done = '0; eng_err = '0; eng_flushed = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R9 reset irq", 32'(irq), 32'd0);
        check("R9 reset start", 32'(eng_start), 32'd0);
        bus_read(a_stat(0), d);
        check("R9 reset status", d, 32'd0);
        bus_read(A_SUMM, d);
        check("R9 reset summary", d, 32'd0);
    endtask

    task automatic t_start_and_queue;
        logic [31:0] d;
        bus_write(a_cmd(3), 32'h1000_0040);
        check("R1 start pulse", 32'(eng_start), 32'h0008);
        check("R1 start ptr", eng_ptr[32*3 +: 32], 32'h1000_0040);
        @(negedge clk);
        check("R1 pulse one cycle", 32'(eng_start), 32'd0);
        bus_write(a_cmd(3), 32'h0000_2000);
        check("R2 no start when busy", 32'(eng_start), 32'd0);
        bus_read(a_stat(3), d);
        check("R2 queued status", d, 32'h21);
        bus_write(a_cmd(3), 32'h0000_3000);
        eng_pulse(3, 1'b0, 1'b0);
        check("R2 queued start", 32'(eng_start), 32'h0008);
        check("R2 queued ptr", eng_ptr[32*3 +: 32], 32'h0000_2000);
        bus_read(a_stat(3), d);
        check("R3 status busy+avail", d, 32'h03);
        eng_pulse(3, 1'b0, 1'b0);
        check("R2 third write ignored", 32'(eng_start), 32'd0);
        bus_read(a_stat(3), d);
        check("R3 status idle+avail", d, 32'h02);
        bus_read(A_SUMM, d);
        check("R6 summary ch3", d, 32'h8);
        bus_read(a_cmd(3), d);
        check("R10 cmd reads zero", d, 32'd0);
    endtask

    task automatic t_result_read;
        logic [31:0] d;
        bus_read(a_rslt(3), d);
        check("R4 first result", d, 32'h8000_0002);
        bus_read(a_rslt(3), d);
        check("R4 second result", d, 32'h8000_0002);
        bus_read(a_rslt(3), d);
        check("R4 empty read", d, 32'd0);
        bus_read(A_SUMM, d);
        check("R6 summary cleared", d, 32'd0);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        bus_write(a_cmd(5), 32'hA0);
        eng_pulse(5, 1'b1, 1'b0);
        bus_write(a_cmd(5), 32'hB0);
        eng_pulse(5, 1'b0, 1'b0);
        bus_write(a_cmd(5), 32'hC0);
        eng_pulse(5, 1'b0, 1'b1);
        bus_read(a_stat(5), d);
        check("R5 overflow status", d, 32'h12);
        bus_read(a_rslt(5), d);
        check("R3 error result", d, 32'h8000_0008);
        bus_read(a_rslt(5), d);
        check("R5 second kept", d, 32'h8000_0002);
        bus_read(a_rslt(5), d);
        check("R5 third dropped", d, 32'd0);
        bus_read(a_stat(5), d);
        check("R5 overflow sticky", d, 32'h10);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        bus_write(a_cmd(7), 32'h700);
        bus_write(a_flush(7), 32'hDEAD);
        check("R8 flush pulse", 32'(eng_flush), 32'h0080);
        eng_pulse(7, 1'b0, 1'b1);
        bus_read(a_stat(7), d);
        check("R3 flushed avail", d, 32'h02);
        bus_read(A_SUMM, d);
        check("R6 flushed hidden", d, 32'd0);
        check("R7 irq low hidden", 32'(irq), 32'd0);
        bus_write(a_cfg(7), 32'h3);
        check("R7 irq with report", 32'(irq), 32'd1);
        bus_read(A_SUMM, d);
        check("R6 flushed reported", d, 32'h80);
        bus_write(a_cfg(7), 32'h2);
        check("R7 irq disabled", 32'(irq), 32'd0);
        bus_read(a_rslt(7), d);
        check("R3 flushed word", d, 32'h8000_0004);
        bus_write(a_flush(7), 32'h0);
        check("R8 idle flush none", 32'(eng_flush), 32'd0);
    endtask

    task automatic t_cfg_irq;
        logic [31:0] d;
        bus_write(a_cfg(1), 32'hFFFF_FFFF);
        bus_read(a_cfg(1), d);
        check("R9 cfg readback", d, 32'h3);
        bus_write(a_cfg(2), 32'h1);
        bus_write(a_cmd(2), 32'h200);
        eng_pulse(2, 1'b0, 1'b0);
        check("R7 irq on result", 32'(irq), 32'd1);
        bus_read(a_rslt(2), d);
        check("R4 ch2 result", d, 32'h8000_0002);
        check("R7 irq after read", 32'(irq), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        eng_done = '0; eng_err = '0; eng_flushed = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_start_and_queue;
        t_result_read;
        t_overflow;
        t_flush;
        t_cfg_irq;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule